// File: doc/BRIEF.md
# Multiphase PWM Phase Sequencer

This block produces up to four staggered PWM enable windows for a multiphase buck controller. On each master-clock tick, a period counter advances. Each active phase is started at an equal fraction of the switching period. A phase output rises at its start slot and stays high until an external duty compare signal for that phase ends the pulse. Because the phases are independent, their pulses can overlap and a phase can stay on for almost the whole period.

The number of fitted phases is not written by software. It is taken from the board wiring. While the block waits and during a short detection window, the block does not drive the phase-3 and phase-4 pins. Instead it enables a weak pull-down on them and senses whether either pin is strapped high. The window lasts a fixed number of master-clock ticks. During it, every PWM output is held low. At the last tick of the window, the phase count is latched. A strapped pin then stays in high impedance, and an unstrapped pin becomes a normal PWM output. The ramp generation, current balancing and analog comparison that produce the duty compare signals are outside this block.

Top module: `pwm_phase_sequencer`

## Requirements
- R1: After reset, all PWM outputs are 0, the output enables are 4'b0011 (phases 1 and 2 driven, phases 3 and 4 released), the pull-down enables are 2'b11, and the reported phase count is 4.
- R2: A pulse on `det_start_i` while idle opens a detection window of DET_TICKS (default 4) ticks. The pull-down enables stay 2'b11 until the edge that consumes the last tick of the window, and are 2'b00 from then on.
- R3: Before and during detection, every PWM output is 0, whatever `duty_end_i` does.
- R4: The count latched on the last detection tick is decoded from the sense inputs (bit 0 = phase 3 pin high, bit 1 = phase 4 pin high). With bit 1 clear the count is 4, and bit 0 is disregarded. With bit 1 set and bit 0 clear the count is 3. With both bits set the count is 2.
- R5: After detection, the output enable of phase p (p = 0..3) is 1 exactly when p is below the latched count. A PWM output never rises on a phase whose enable is 0.
- R6: In the running state, with a tick on every cycle and a period of P ticks, phase p rises on the edge that consumes tick number p*P/K (counting from 0 at the first tick after detection ends). K is the latched count. This pattern repeats every P ticks.
- R7: A risen phase stays high until its own `duty_end_i` bit is seen at a clock edge, and falls on that edge. Any set of phases may be high at once.
- R8: When a phase's start slot and its `duty_end_i` bit occur on the same edge, the phase is high after that edge.
- R9: The detection counter and the period counter advance only on edges where `tick_i` is 1.
- R10: Once running, a `det_start_i` pulse and changes on the sense inputs have no effect on the count, the enables or the pull-downs until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Master-clock tick, one-cycle enable |
| det_start_i | input | 1 | Opens the detection window (accepted only while idle) |
| strap_hi_i | input | 2 | Pin-high sense: bit 0 phase 3, bit 1 phase 4 |
| duty_end_i | input | 4 | Per-phase duty compare; ends the pulse of that phase |
| pwm_o | output | 4 | Per-phase PWM level |
| pwm_oe_o | output | 4 | Per-phase output-drive enable (0 = high impedance) |
| pulldn_o | output | 2 | Weak pull-down enable on the phase 3 and phase 4 pins |
| phase_cnt_o | output | 3 | Detected number of phases (2, 3 or 4) |

## Verification
The start slot of a phase and the duty compare of the same phase can land on the same edge. Holding every `duty_end_i` bit high for a whole period forces this collision on every active phase. Under the start-wins rule (R8), each phase then shows a one-cycle pulse exactly at its slot. The bench predicts that slot from the latched count and compares it cycle by cycle. A second pairing is a `det_start_i` pulse and changed sense inputs arriving while the block is already running. This is judged by the count, enables and pull-downs staying unchanged.

// File: rtl/pps_pkg.sv
package pps_pkg;

   localparam int PPS_NUM_PH = 4;
   localparam int PPS_CNT_W  = 3;

   typedef enum logic [1:0] {
      SEQ_IDLE   = 2'd0,
      SEQ_DETECT = 2'd1,
      SEQ_RUN    = 2'd2
   } seq_state_e;

   // Sense bit 1 (phase 4 pin high) gates bit 0 (phase 3 pin high).
   function automatic logic [PPS_CNT_W-1:0] pps_decode(input logic [1:0] hi);
      logic [PPS_CNT_W-1:0] k;
      if (!hi[1])     k = 3'd4;
      else if (hi[0]) k = 3'd2;
      else            k = 3'd3;
      return k;
   endfunction

endpackage

// File: rtl/pps_detect.sv
module pps_detect
   import pps_pkg::*;
#(
   parameter int DET_TICKS = 4,
   localparam int DET_W = (DET_TICKS > 1) ? $clog2(DET_TICKS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick_i,
   input  logic                 det_start_i,
   input  logic [1:0]           strap_hi_i,
   output logic                 run_o,
   output logic [1:0]           pulldn_o,
   output logic [PPS_CNT_W-1:0] phase_cnt_o
);

   localparam logic [DET_W-1:0] DET_LAST = DET_W'(DET_TICKS - 1);

   seq_state_e           state_q;
   logic [DET_W-1:0]     det_cnt_q;
   logic [PPS_CNT_W-1:0] cnt_q;

   generate
      if (DET_TICKS < 1) begin : g_bad_det
         $error("DET_TICKS must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= SEQ_IDLE;
         det_cnt_q <= '0;
         cnt_q     <= 3'd4;
      end else begin
         unique case (state_q)
            SEQ_IDLE: begin
               if (det_start_i) begin
                  state_q   <= SEQ_DETECT;
                  det_cnt_q <= '0;
               end
            end
            SEQ_DETECT: begin
               if (tick_i) begin
                  if (det_cnt_q == DET_LAST) begin
                     cnt_q   <= pps_decode(strap_hi_i);
                     state_q <= SEQ_RUN;
                  end else begin
                     det_cnt_q <= det_cnt_q + 1'b1;
                  end
               end
            end
            SEQ_RUN: begin
               state_q <= SEQ_RUN;
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign run_o       = (state_q == SEQ_RUN);
   assign pulldn_o    = run_o ? 2'b00 : 2'b11;
   assign phase_cnt_o = cnt_q;

   AST_CNT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_cnt_o >= 3'd2) && (phase_cnt_o <= 3'd4)); // R4

   AST_DET_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SEQ_DETECT && !tick_i) |=> (state_q == SEQ_DETECT) && $stable(det_cnt_q)); // R9

   AST_CNT_FROZEN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      run_o |=> run_o && $stable(phase_cnt_o)); // R10

endmodule

// File: rtl/pps_slot_timer.sv
module pps_slot_timer
   import pps_pkg::*;
#(
   parameter int PERIOD_TICKS = 12,
   localparam int PER_W = $clog2(PERIOD_TICKS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  run_i,
   input  logic                  tick_i,
   input  logic [PPS_CNT_W-1:0]  phase_cnt_i,
   output logic [PPS_NUM_PH-1:0] start_o
);

   localparam logic [PER_W-1:0] PER_LAST = PER_W'(PERIOD_TICKS - 1);

   logic [PER_W-1:0] per_q;

   generate
      if ((PERIOD_TICKS < 12) || (PERIOD_TICKS % 12 != 0)) begin : g_bad_per
         $error("PERIOD_TICKS must be a positive multiple of 12");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || !run_i) begin
         per_q <= '0;
      end else if (tick_i) begin
         per_q <= (per_q == PER_LAST) ? '0 : per_q + 1'b1;
      end
   end

   for (genvar p = 0; p < PPS_NUM_PH; p++) begin : g_slot
      localparam int OFF2 = p * PERIOD_TICKS / 2;
      localparam int OFF3 = p * PERIOD_TICKS / 3;
      localparam int OFF4 = p * PERIOD_TICKS / 4;
      logic hit;
      logic fitted;

      always_comb begin
         unique case (phase_cnt_i)
            3'd2:    hit = (int'(per_q) == OFF2);
            3'd3:    hit = (int'(per_q) == OFF3);
            3'd4:    hit = (int'(per_q) == OFF4);
            default: hit = 1'b0;
         endcase
      end

      assign fitted     = (PPS_CNT_W'(p) < phase_cnt_i);
      assign start_o[p] = run_i & tick_i & fitted & hit;
   end

   AST_ONE_START: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(start_o)); // R6

   AST_PER_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !tick_i) |=> $stable(per_q)); // R9

   AST_NO_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |-> (start_o == '0)); // R3

endmodule

// File: rtl/pps_phase_out.sv
module pps_phase_out (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic start_i,
   input  logic duty_end_i,
   output logic pwm_o
);

   logic pwm_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !run_i) begin
         pwm_q <= 1'b0;
      end else if (start_i) begin
         pwm_q <= 1'b1;
      end else if (duty_end_i) begin
         pwm_q <= 1'b0;
      end
   end

   assign pwm_o = pwm_q;

   AST_RISE_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwm_q) |-> $past(start_i)); // R6

   AST_START_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && duty_end_i) |=> pwm_q); // R8

   AST_FALL_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && pwm_q && duty_end_i && !start_i) |=> !pwm_q); // R7

endmodule

// File: rtl/pwm_phase_sequencer.sv
module pwm_phase_sequencer
   import pps_pkg::*;
#(
   parameter int PERIOD_TICKS = 12,
   parameter int DET_TICKS    = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_i,
   input  logic       det_start_i,
   input  logic [1:0] strap_hi_i,
   input  logic [3:0] duty_end_i,
   output logic [3:0] pwm_o,
   output logic [3:0] pwm_oe_o,
   output logic [1:0] pulldn_o,
   output logic [2:0] phase_cnt_o
);

   logic                  run;
   logic [PPS_CNT_W-1:0]  cnt;
   logic [PPS_NUM_PH-1:0] start;

   pps_detect #(.DET_TICKS(DET_TICKS)) u_detect (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_i      (tick_i),
      .det_start_i (det_start_i),
      .strap_hi_i  (strap_hi_i),
      .run_o       (run),
      .pulldn_o    (pulldn_o),
      .phase_cnt_o (cnt)
   );

   pps_slot_timer #(.PERIOD_TICKS(PERIOD_TICKS)) u_slots (
      .clk         (clk),
      .rst_n       (rst_n),
      .run_i       (run),
      .tick_i      (tick_i),
      .phase_cnt_i (cnt),
      .start_o     (start)
   );

   for (genvar p = 0; p < PPS_NUM_PH; p++) begin : g_ph
      pps_phase_out u_out (
         .clk        (clk),
         .rst_n      (rst_n),
         .run_i      (run),
         .start_i    (start[p]),
         .duty_end_i (duty_end_i[p]),
         .pwm_o      (pwm_o[p])
      );
      if (p < 2) begin : g_fixed
         assign pwm_oe_o[p] = 1'b1;
      end else begin : g_strap
         assign pwm_oe_o[p] = run & (PPS_CNT_W'(p) < cnt);
      end
   end

   assign phase_cnt_o = cnt;

   AST_PWM_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_o & ~pwm_oe_o) == 4'b0000); // R5

   AST_PULLDN_OFF_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_o != 4'b0000) |-> (pulldn_o == 2'b00)); // R2

endmodule

// File: tb/pwm_phase_sequencer_bench.sv
module pwm_phase_sequencer_bench;

   localparam int P = 12;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       tick_i;
   logic       det_start_i;
   logic [1:0] strap_hi_i;
   logic [3:0] duty_end_i;
   logic [3:0] pwm_o;
   logic [3:0] pwm_oe_o;
   logic [1:0] pulldn_o;
   logic [2:0] phase_cnt_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   pwm_phase_sequencer #(.PERIOD_TICKS(P), .DET_TICKS(4)) u_pwm_phase_sequencer (
      .clk, .rst_n, .tick_i, .det_start_i, .strap_hi_i, .duty_end_i,
      .pwm_o, .pwm_oe_o, .pulldn_o, .phase_cnt_o
   );

   // {strap bit1, strap bit0, expected count, expected enables}
   localparam logic [8:0] VEC [4] = '{
      {1'b0, 1'b0, 3'd4, 4'b1111},
      {1'b0, 1'b1, 3'd4, 4'b1111},
      {1'b1, 1'b0, 3'd3, 4'b0111},
      {1'b1, 1'b1, 3'd2, 4'b0011}
   };

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n       = 1'b0;
      tick_i      = 1'b1;
      det_start_i = 1'b0;
      duty_end_i  = 4'b0000;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // Leaves the bench at the negedge after the edge that ends detection.
   task automatic do_detect();
      det_start_i = 1'b1;
      @(negedge clk);
      det_start_i = 1'b0;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk("R2 pull-down held", pulldn_o, 2'b11);
         chk("R3 blanked", pwm_o, 0);
      end
      @(negedge clk);
      chk("R2 pull-down released", pulldn_o, 2'b00);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         n_chk++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      strap_hi_i = 2'b00;
      do_reset();
      chk("R1 pwm", pwm_o, 0);
      chk("R1 oe", pwm_oe_o, 4'b0011);
      chk("R1 pulldn", pulldn_o, 2'b11);
      chk("R1 count", phase_cnt_o, 4);

      // Table walk: detection decode, enables, stagger with start/end collision.
      for (int v = 0; v < 4; v++) begin
         int k;
         strap_hi_i = VEC[v][8:7];
         do_reset();
         duty_end_i = 4'b1111;
         do_detect();
         k = int'(VEC[v][6:4]);
         chk("R4 count", phase_cnt_o, k);
         chk("R5 enables", pwm_oe_o, VEC[v][3:0]);
         for (int j = 0; j < 2 * P; j++) begin
            logic [3:0] exp;
            @(negedge clk);
            for (int p = 0; p < 4; p++)
               exp[p] = (p < k) && ((j % P) == p * P / k);
            chk("R6 R8 stagger", pwm_o, exp);
         end
      end

      // R7: without duty end every active phase stays high and they overlap.
      strap_hi_i = 2'b00;
      do_reset();
      do_detect();
      repeat (P) @(negedge clk);
      chk("R7 overlap", pwm_o, 4'b1111);
      duty_end_i = 4'b0010;
      @(negedge clk);
      duty_end_i = 4'b0000;
      chk("R7 single fall", pwm_o, 4'b1101);

      // R10: re-detect request and new straps ignored while running.
      strap_hi_i  = 2'b11;
      det_start_i = 1'b1;
      @(negedge clk);
      det_start_i = 1'b0;
      repeat (6) @(negedge clk);
      chk("R10 count kept", phase_cnt_o, 4);
      chk("R10 enables kept", pwm_oe_o, 4'b1111);
      chk("R10 pulldn kept", pulldn_o, 2'b00);

      // R9: detection does not progress without ticks.
      strap_hi_i = 2'b10;
      do_reset();
      tick_i      = 1'b0;
      det_start_i = 1'b1;
      @(negedge clk);
      det_start_i = 1'b0;
      repeat (8) @(negedge clk);
      chk("R9 detect stalled", pulldn_o, 2'b11);
      chk("R3 blanked during stall", pwm_o, 0);
      tick_i = 1'b1;
      repeat (4) @(negedge clk);
      chk("R9 detect resumes", pulldn_o, 2'b00);
      chk("R4 three-phase", phase_cnt_o, 3);
      // R9: no starts while ticks are absent in run.
      tick_i = 1'b0;
      repeat (P + 2) @(negedge clk);
      chk("R9 no start without tick", pwm_o, 0);
      tick_i = 1'b1;
      @(negedge clk);
      chk("R9 first start on tick", pwm_o, 4'b0001);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule